// File: doc/BRIEF.md
# Trigger Pattern Time Multiplexer

This block takes the 96-channel hit pattern of one beam crossing and sends it over a 16-bit parallel link interface as six consecutive words. It runs on a fast clock at six times the beam-clock rate. A one-cycle crossing strobe, asserted once per beam crossing, marks the cycle in which the pattern input is valid. On that edge the pattern is combined with a stored per-channel mask and held. The following six fast cycles then carry channels 0-15, 16-31 and so on up to 80-95. A frame-alignment bit goes with the first word of each crossing.

The mask has two uses, chosen by a mode input that is sampled with the crossing strobe. In suppress mode, a mask bit set to 1 forces its channel to zero, which silences known bad channels. In inject mode, the pattern input is ignored and the mask contents are sent instead, so arbitrary test patterns can be fed to the downstream trigger logic. The mask is written one 16-bit word at a time through a simple write port. A write changes only the crossings whose strobe comes after it.

Top module: `trig_pattern_mux`

## Requirements
- R1: While reset is asserted and after it is released, until the first crossing strobe, the link word is 0 and the align bit is 0.
- R2: When the crossing strobe is sampled high at a clock edge, the next six cycles carry words 0 to 5 of that crossing in order. Word k holds channels 16k to 16k+15, with channel 16k on bit 0. The align bit is 1 in the first of these cycles and 0 in the other five.
- R3: In suppress mode (mode input 0 at the strobe), each output channel equals its pattern bit AND NOT its mask bit.
- R4: In inject mode (mode input 1 at the strobe), each output channel equals its mask bit, whatever the pattern input holds.
- R5: Changes on the pattern input between strobes do not change the words of the crossing in progress.
- R6: A mask write to address a (0 to 5) sets channels 16a to 16a+15 of the mask. The new value appears only in crossings whose strobe is sampled after the write edge. A write in the same edge as a strobe does not affect that crossing.
- R7: If no new strobe arrives after word 5, the link word is 0 and the align bit is 0 until the next strobe.
- R8: A strobe that arrives before word 5 has been sent cuts the sequence short. The next cycle carries word 0 of the new crossing with the align bit set.
- R9: Changes on the mode input between strobes do not affect the crossing in progress.
- R10: Mask writes to addresses 6 and 7 are ignored and leave the whole mask unchanged.
- R11: The mask is all zeros after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, six times the beam clock |
| rstN | input | 1 | Active-low synchronous reset |
| xingStrobe | input | 1 | One-cycle crossing strobe; pattern and mode are valid with it |
| patIn | input | 96 | Hit pattern of the crossing, channel n on bit n |
| injectMode | input | 1 | 0 = suppress masked channels, 1 = send mask as pattern |
| maskWrEn | input | 1 | Mask word write enable |
| maskWrAddr | input | 3 | Mask word index, 0 to 5 valid |
| maskWrData | input | 16 | Mask word value, bit j = channel 16*addr+j |
| linkWord | output | 16 | Multiplexed output word |
| linkAlign | output | 1 | High on the first word of each crossing |

## Verification
A wrong phase counter shows at the ports within one fast cycle. Words come out of order, the align bit lands on the wrong word, or the output fails to go to zero after word 5. A fault in the holding register or the mask storage shows up in the content of the very next crossing. The bench therefore compares every word of every crossing, and sends mask writes, pattern changes and mode changes in the middle of crossings. In inject mode the whole mask is visible at the ports, so mask corruption, including corruption caused by ignored addresses, can be seen directly.

// File: rtl/trig_mux_pkg.sv
package trig_mux_pkg;
  typedef struct packed {
    logic capture;   // latch a new crossing this edge
    logic active;    // a word of the current crossing is on the link
    logic first;     // the word on the link is word 0
  } muxCtl_t;
endpackage

// File: rtl/trig_mux_ctrl.sv
module trig_mux_ctrl
  import trig_mux_pkg::*;
#(
  parameter int WORDS = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      xingStrobe,
  output muxCtl_t                   ctl,
  output logic [$clog2(WORDS)-1:0]  phase
);
  localparam int PH_W = $clog2(WORDS);
  localparam logic [PH_W-1:0] LAST = PH_W'(WORDS - 1);

  logic active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= '0;
      active <= 1'b0;
    end else if (xingStrobe) begin
      phase  <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (phase == LAST) begin
        active <= 1'b0;
        phase  <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.capture = xingStrobe;
    ctl.active  = active;
    ctl.first   = active && (phase == '0);
  end

  // R2: the phase steps by one between strobes
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    (active && !xingStrobe && phase != LAST) |=> (active && phase == $past(phase) + 1'b1));

  // R7: the sequence stops after the last word when no strobe arrives
  a_r7_stop_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (active && !xingStrobe && phase == LAST) |=> !active);
endmodule

// File: rtl/trig_mux_datapath.sv
module trig_mux_datapath
  import trig_mux_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 6,
  parameter int ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  muxCtl_t                   ctl,
  input  logic [$clog2(WORDS)-1:0]  phase,
  input  logic [WORD_W*WORDS-1:0]   patIn,
  input  logic                      injectMode,
  input  logic                      maskWrEn,
  input  logic [ADDR_W-1:0]         maskWrAddr,
  input  logic [WORD_W-1:0]         maskWrData,
  output logic [WORD_W-1:0]         linkWord,
  output logic                      linkAlign
);
  logic [WORDS-1:0][WORD_W-1:0] maskReg;
  logic [WORDS-1:0][WORD_W-1:0] holdReg;
  logic [WORDS-1:0][WORD_W-1:0] patWords;

  assign patWords = patIn;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskReg[w] <= '0;
      end else if (maskWrEn && (maskWrAddr == ADDR_W'(w))) begin
        maskReg[w] <= maskWrData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdReg[w] <= '0;
      end else if (ctl.capture) begin
        holdReg[w] <= injectMode ? maskReg[w] : (patWords[w] & ~maskReg[w]);
      end
    end
  end

  always_comb begin
    linkWord  = ctl.active ? holdReg[phase] : '0;
    linkAlign = ctl.first;
  end

  // R5: the held crossing changes only on a capture
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(holdReg));

  // R2: align follows each capture
  a_r2_align_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> linkAlign);

  // R2: align is a single-cycle marker unless a new crossing starts
  a_r2_align_once: assert property (@(posedge clk) disable iff (!rstN)
    (linkAlign && !ctl.capture) |=> !linkAlign);
endmodule

// File: rtl/trig_pattern_mux.sv
module trig_pattern_mux
  import trig_mux_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 6,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     xingStrobe,
  input  logic [WORD_W*WORDS-1:0]  patIn,
  input  logic                     injectMode,
  input  logic                     maskWrEn,
  input  logic [ADDR_W-1:0]        maskWrAddr,
  input  logic [WORD_W-1:0]        maskWrData,
  output logic [WORD_W-1:0]        linkWord,
  output logic                     linkAlign
);
  localparam int PH_W = $clog2(WORDS);

  muxCtl_t         ctl;
  logic [PH_W-1:0] phase;

  trig_mux_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xingStrobe (xingStrobe),
    .ctl        (ctl),
    .phase      (phase)
  );

  trig_mux_datapath #(.WORD_W(WORD_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .phase      (phase),
    .patIn      (patIn),
    .injectMode (injectMode),
    .maskWrEn   (maskWrEn),
    .maskWrAddr (maskWrAddr),
    .maskWrData (maskWrData),
    .linkWord   (linkWord),
    .linkAlign  (linkAlign)
  );
endmodule

// File: tb/trig_pattern_mux_tb.sv
module trig_pattern_mux_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        xingStrobe;
  logic [95:0] patIn;
  logic        injectMode;
  logic        maskWrEn;
  logic [2:0]  maskWrAddr;
  logic [15:0] maskWrData;
  logic [15:0] linkWord;
  logic        linkAlign;

  int errors = 0;
  int checks = 0;
  logic [95:0] modelMask;
  logic [95:0] expPat;

  always #2 clk = ~clk;

  trig_pattern_mux u_dut (
    .clk(clk), .rstN(rstN), .xingStrobe(xingStrobe), .patIn(patIn),
    .injectMode(injectMode), .maskWrEn(maskWrEn), .maskWrAddr(maskWrAddr),
    .maskWrData(maskWrData), .linkWord(linkWord), .linkAlign(linkAlign)
  );

  function automatic logic [95:0] calcPat(input logic [95:0] p, input logic [95:0] m,
                                          input logic md);
    return md ? m : (p & ~m);
  endfunction

  task automatic check(input string tag, input logic [15:0] w, input logic a,
                       input logic [15:0] ew, input logic ea);
    checks++;
    if (w !== ew || a !== ea) begin
      errors++;
      $display("FAIL %s: word=%h align=%b expected word=%h align=%b", tag, w, a, ew, ea);
    end
  endtask

  // drive at a negedge: strobe sampled at the next posedge
  task automatic launch(input logic [95:0] p, input logic md);
    expPat     = calcPat(p, modelMask, md);
    patIn      = p;
    injectMode = md;
    xingStrobe = 1'b1;
    @(negedge clk);
    xingStrobe = 1'b0;
  endtask

  task automatic writeMask(input logic [2:0] a, input logic [15:0] d);
    maskWrEn = 1'b1; maskWrAddr = a; maskWrData = d;
    if (a < 3'd6) modelMask[a*16 +: 16] = d;
    @(negedge clk);
    maskWrEn = 1'b0;
  endtask

  // check n words; optionally disturb inputs between them
  task automatic runWords(input int n, input string tag, input bit disturb);
    for (int k = 0; k < n; k++) begin
      check(tag, linkWord, linkAlign, expPat[k*16 +: 16], k == 0);
      if (disturb) begin
        logic [2:0] a;
        logic [15:0] d;
        patIn      = {$urandom, $urandom, $urandom};
        injectMode = $urandom;
        a = 3'($urandom % 8);
        d = 16'($urandom);
        maskWrEn = 1'b1; maskWrAddr = a; maskWrData = d;
        if (a < 3'd6) modelMask[a*16 +: 16] = d;
      end
      @(negedge clk);
      maskWrEn = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: word=%h align=%b expected word=done align=done", linkWord, linkAlign);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [95:0] p;
    void'($urandom(32'd1234));
    rstN = 1'b0; xingStrobe = 1'b0; patIn = '1; injectMode = 1'b0;
    maskWrEn = 1'b0; maskWrAddr = '0; maskWrData = '0; modelMask = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", linkWord, linkAlign, 16'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", linkWord, linkAlign, 16'h0, 1'b0);

    // R11: mask zero after reset, shown through inject mode
    launch(96'hDEAD_BEEF_0123_4567_89AB_CDEF, 1'b1);
    runWords(6, "R11 R4 reset mask", 0);

    // R2 R3: suppress with empty mask is transparent
    launch(96'h0123_4567_89AB_CDEF_FEDC_BA98, 1'b0);
    runWords(6, "R2 R3 clear mask", 0);
    check("R7 idle after word 5", linkWord, linkAlign, 16'h0, 1'b0);
    @(negedge clk);
    check("R7 idle hold", linkWord, linkAlign, 16'h0, 1'b0);

    // R3: masked channels suppressed
    for (int a = 0; a < 6; a++) writeMask(3'(a), 16'h00FF ^ 16'(a * 16'h1111));
    launch('1, 1'b0);
    runWords(6, "R3 suppress", 0);

    // R4: inject ignores pattern
    launch(96'h0, 1'b1);
    runWords(6, "R4 inject", 0);

    // R10: out-of-range addresses ignored
    writeMask(3'd6, 16'hFFFF);
    writeMask(3'd7, 16'hA5A5);
    launch('1, 1'b1);
    runWords(6, "R10 ignored addr", 0);

    // R6: write in strobe edge not used by that crossing
    expPat = calcPat(96'h0, modelMask, 1'b1);
    patIn = '0; injectMode = 1'b1; xingStrobe = 1'b1;
    maskWrEn = 1'b1; maskWrAddr = 3'd0; maskWrData = 16'h1234;
    modelMask[15:0] = 16'h1234;
    @(negedge clk);
    xingStrobe = 1'b0; maskWrEn = 1'b0;
    runWords(6, "R6 same-edge write", 0);
    launch('0, 1'b1);
    runWords(1, "R6 write applied next", 0);
    runWords(0, "", 0);

    // R8: early strobe restarts
    launch(96'h1111_2222_3333_4444_5555_6666, 1'b0);
    runWords(3, "R8 first part", 0);
    launch(96'h7777_8888_9999_AAAA_BBBB_CCCC, 1'b0);
    runWords(6, "R8 restart", 0);

    // R5 R6 R9: random crossings with disturbances mid-sequence
    for (int i = 0; i < 200; i++) begin
      p = {$urandom, $urandom, $urandom};
      launch(p, 1'($urandom));
      runWords(6, "R5 R6 R9 random", 1);
      if ($urandom % 2) begin
        check("R7 random gap", linkWord, linkAlign, 16'h0, 1'b0);
        @(negedge clk);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule